// File: doc/BRIEF.md
# SPI Master Serial Engine

This block is the bit-level core of an SPI master. It takes words from the read side of a transmit FIFO, shifts each one out on MOSI most significant bit first, and collects the bits sampled on MISO into words for the write side of a receive FIFO. Four static inputs set its behaviour: a control word, a clock divider, a slave-select enable vector and, for receive-only bursts, a frame count. The control word selects the frame length, the clock polarity, the clock phase and the transfer mode.

SCLK is derived from the system clock. Each half period lasts half the programmed divider, and the divider must be even. While frames are shifting, the engine pulls low the slave-select lines that are set in the enable vector. Frames that follow each other with no gap keep the line low. The line returns high after the final clock edge of a burst, with no action from software. A busy output covers both the shifting and any frame that is still pending.

Top module: `spi_frame_engine`

## Requirements
- R1: Control bits [3:0] hold the frame length minus one (1 to 16 bits). Each frame is sent and received most significant bit first, and a received word carries its bits right-aligned with zeros above them.
- R2: Control bit 7 sets the idle SCLK level. Control bit 6 sets the phase: at 0, data is sampled on the leading edge and changed on the trailing edge; at 1, data is changed on the leading edge and sampled on the trailing edge.
- R3: In mode 0 (control bits [9:8] = 0), each frame pops one transmit word. After the frame's final edge, rx_push_o pulses for one cycle with the received word.
- R4: In mode 1 (transmit only), transmit words are popped and shifted out, and rx_push_o never rises.
- R5: In mode 2 (receive only), a pulse on rx_go_i loads rx_frames_i. The engine then shifts out zeros for that many frames and pushes each received word. It pops nothing.
- R6: Mode 3 starts no transfer: no pop, no SCLK edge, and slave select stays high.
- R7: With half = div_i[15:1], SCLK toggles every half system clocks. Bit 0 of the divider has no effect. The first edge comes half cycles after slave select falls. A burst of F frames of N bits holds slave select low for 2·N·half cycles per frame and makes 2·N edges per frame.
- R8: A divider below 2 produces no SCLK edge and pops no word. Pending data stays in the FIFO and busy_o stays high.
- R9: Slave select is active low and idles high. While a burst is active, ss_no equals the inverse of ss_sel_i. Frames that follow each other keep it low.
- R10: busy_o is high while a frame is shifting or work is pending: a non-empty transmit FIFO in modes 0 and 1, or frames still to receive in mode 2. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 10 | Frame length, phase, polarity, mode |
| div_i | input | 16 | SCLK divider, even values only |
| ss_sel_i | input | 4 | One-hot slave-select enable |
| rx_frames_i | input | 16 | Frame count for receive-only bursts |
| rx_go_i | input | 1 | Starts a receive-only burst |
| tx_empty_i | input | 1 | Transmit FIFO is empty |
| tx_data_i | input | 16 | Transmit FIFO head word |
| tx_pop_o | output | 1 | Pops the transmit FIFO head |
| rx_push_o | output | 1 | Writes rx_data_o into the receive FIFO |
| rx_data_o | output | 16 | Received frame, right-aligned |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_no | output | 4 | Slave-select lines, active low |
| busy_o | output | 1 | Engine is shifting or has pending work |

## Verification
A burst starts on the clock edge after data becomes available. At that edge tx_pop_o is high, and slave select is low from that edge on. The first SCLK change appears half cycles later, and every later change follows half cycles after the one before. The final edge of a burst raises slave select and, in the same edge, raises rx_push_o for one cycle. The bench samples every output on the falling system clock. It measures the distance from the fall of slave select to the first SCLK change, the number of cycles slave select stays low and the number of edges. It compares each of these with the values derived from half, N and the frame count.

// File: rtl/spife_pkg.sv
package spife_pkg;
  typedef enum logic [1:0] {
    MODE_TXRX   = 2'd0,
    MODE_TXONLY = 2'd1,
    MODE_RXONLY = 2'd2,
    MODE_RSVD   = 2'd3
  } xfer_mode_e;

  localparam int unsigned CTRL_W    = 10;
  localparam int unsigned CPHA_BIT  = 6;
  localparam int unsigned CPOL_BIT  = 7;
  localparam int unsigned MODE_LSB  = 8;
endpackage

// File: rtl/spife_tick.sv
module spife_tick #(
  parameter int unsigned HW = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [HW-1:0] half_i,
  output logic          tick_o
);
  logic [HW-1:0] cnt_q;
  logic          at_end;

  assign at_end = (cnt_q == (half_i - HW'(1)));
  assign tick_o = run_i && (half_i != '0) && at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + HW'(1);
  end
endmodule

// File: rtl/spife_shift.sv
module spife_shift #(
  parameter int unsigned FW   = 16,
  localparam int unsigned SZW = $clog2(FW)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [FW-1:0]  data_i,
  input  logic           cpha_i,
  input  logic [SZW-1:0] size_i,
  input  logic           lead_i,
  input  logic           trail_i,
  input  logic           miso_i,
  output logic           mosi_o,
  output logic [FW-1:0]  rx_word_o
);
  logic [FW-1:0] txs_q, rxs_q;
  logic          mosi_q;
  logic          sample, drive;

  // phase 0: sample leading, drive trailing; phase 1: the reverse
  assign sample = cpha_i ? trail_i : lead_i;
  assign drive  = cpha_i ? lead_i  : trail_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txs_q  <= '0;
      mosi_q <= 1'b0;
    end else if (load_i) begin
      // phase 1 keeps the previous bit on the wire until the first leading edge
      txs_q  <= cpha_i ? data_i : (data_i << 1);
      mosi_q <= cpha_i ? mosi_q : data_i[size_i];
    end else if (drive) begin
      txs_q  <= txs_q << 1;
      mosi_q <= txs_q[size_i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rxs_q <= '0;
    else if (load_i)  rxs_q <= '0;
    else if (sample)  rxs_q <= {rxs_q[FW-2:0], miso_i};
  end

  assign mosi_o    = mosi_q;
  assign rx_word_o = sample ? {rxs_q[FW-2:0], miso_i} : rxs_q;
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spife_pkg::*;
#(
  parameter int unsigned FW    = 16,
  parameter int unsigned DIV_W = 16,
  parameter int unsigned NSS   = 4,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned SZW  = $clog2(FW)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [NSS-1:0]    ss_sel_i,
  input  logic [CNT_W-1:0]  rx_frames_i,
  input  logic              rx_go_i,
  input  logic              tx_empty_i,
  input  logic [FW-1:0]     tx_data_i,
  output logic              tx_pop_o,
  output logic              rx_push_o,
  output logic [FW-1:0]     rx_data_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NSS-1:0]    ss_no,
  output logic              busy_o
);
  xfer_mode_e       mode;
  logic             cpha, cpol;
  logic [SZW-1:0]   size;
  logic [DIV_W-2:0] half;
  logic             tx_mode, ro_mode, pending, have_next;
  logic             active_q, ph_q, rx_push_q;
  logic [SZW:0]     edge_q;
  logic [CNT_W-1:0] ro_left_q;
  logic [FW-1:0]    rx_data_q, rx_word;
  logic             tick, last, start, lead, trail;
  logic             unused_cfg;

  assign mode       = xfer_mode_e'(ctrl_i[MODE_LSB +: 2]);
  assign cpha       = ctrl_i[CPHA_BIT];
  assign cpol       = ctrl_i[CPOL_BIT];
  assign size       = ctrl_i[SZW-1:0];
  assign half       = div_i[DIV_W-1:1];
  assign unused_cfg = ^{ctrl_i[CPHA_BIT-1:SZW], div_i[0]};

  assign tx_mode   = (mode == MODE_TXRX) || (mode == MODE_TXONLY);
  assign ro_mode   = (mode == MODE_RXONLY);
  assign pending   = (tx_mode && !tx_empty_i) || (ro_mode && ro_left_q != '0);
  assign have_next = pending && (half != '0);

  spife_tick #(.HW(DIV_W-1)) i_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (active_q),
    .half_i (half),
    .tick_o (tick)
  );

  assign last  = tick && (edge_q == {size, 1'b1});
  assign start = have_next && (!active_q || last);
  assign lead  = tick && !edge_q[0];
  assign trail = tick &&  edge_q[0];

  spife_shift #(.FW(FW)) i_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (start),
    .data_i    (tx_mode ? tx_data_i : '0),
    .cpha_i    (cpha),
    .size_i    (size),
    .lead_i    (lead),
    .trail_i   (trail),
    .miso_i    (miso_i),
    .mosi_o    (mosi_o),
    .rx_word_o (rx_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      edge_q   <= '0;
      ph_q     <= 1'b0;
    end else begin
      if (tick) ph_q <= ~ph_q;
      if (start) begin
        active_q <= 1'b1;
        edge_q   <= '0;
      end else if (last) begin
        active_q <= 1'b0;
        edge_q   <= '0;
      end else if (tick) begin
        edge_q   <= edge_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   ro_left_q <= '0;
    else if (start && ro_mode)                     ro_left_q <= ro_left_q - 1'b1;
    else if (rx_go_i && ro_mode && ro_left_q == '0) ro_left_q <= rx_frames_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_push_q <= 1'b0;
      rx_data_q <= '0;
    end else begin
      rx_push_q <= last && (mode != MODE_TXONLY);
      if (last) rx_data_q <= rx_word;
    end
  end

  for (genvar g = 0; g < NSS; g++) begin : g_ss
    assign ss_no[g] = ~(active_q && ss_sel_i[g]);
  end

  assign tx_pop_o  = start && tx_mode;
  assign rx_push_o = rx_push_q;
  assign rx_data_o = rx_data_q;
  assign sclk_o    = cpol ^ ph_q;
  assign busy_o    = active_q || pending;
endmodule

// File: rtl/spife_checker.sv
module spife_checker #(
  parameter int unsigned DIV_W = 16,
  parameter int unsigned NSS   = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [9:0]       ctrl_i,
  input logic [DIV_W-1:0] div_i,
  input logic             tx_empty_i,
  input logic             tx_pop_o,
  input logic             rx_push_o,
  input logic             sclk_o,
  input logic [NSS-1:0]   ss_no,
  input logic             busy_o
);
  AST_SS_ONE_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~ss_no) <= 1); // R9

  AST_SS_MEANS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ss_no != '1) |-> busy_o); // R10

  AST_IDLE_SCLK_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ss_no == '1) |-> (sclk_o == ctrl_i[7])); // R2

  AST_NO_PUSH_TXONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[9:8] == 2'd1) |-> !rx_push_o); // R4

  AST_POP_HAS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_o |-> !tx_empty_i); // R3

  AST_NO_POP_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[9:8] == 2'd3) |-> !tx_pop_o); // R6

  AST_NODIV_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_i[DIV_W-1:1] == '0 && $past(div_i[DIV_W-1:1]) == '0 && $stable(ctrl_i))
      |-> $stable(sclk_o)); // R8
endmodule

bind spi_frame_engine spife_checker #(.DIV_W(DIV_W), .NSS(NSS)) i_spife_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ctrl_i     (ctrl_i),
  .div_i      (div_i),
  .tx_empty_i (tx_empty_i),
  .tx_pop_o   (tx_pop_o),
  .rx_push_o  (rx_push_o),
  .sclk_o     (sclk_o),
  .ss_no      (ss_no),
  .busy_o     (busy_o)
);

// File: tb/test_spi_frame_engine.sv
module test_spi_frame_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  ctrl = '0;
  logic [15:0] div = 16'd2;
  logic [3:0]  sel = 4'b0100;
  logic [15:0] rx_frames = '0;
  logic        rx_go = 1'b0;
  logic        tx_empty, tx_pop, rx_push, sclk, mosi, miso, busy;
  logic [15:0] tx_data, rx_data;
  logic [3:0]  ss_n;

  logic [15:0] tx_q [0:7];
  logic [15:0] sw   [0:7];
  logic [15:0] cap  [0:7];
  logic [15:0] got  [0:7];
  int tx_rd, tx_wr, nbits, sf, sb, rx_n, low_cnt, edges, cyc, fall_cyc, first_cyc, ss_bad, bsy_bad;
  logic slv_rst = 1'b1;
  logic prev;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign tx_empty = slv_rst || (tx_rd == tx_wr);
  assign tx_data  = tx_q[tx_rd[2:0]];
  assign miso     = sw[sf[2:0]][sb[3:0]];

  spi_frame_engine i_spi_frame_engine (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_i(ctrl), .div_i(div), .ss_sel_i(sel),
    .rx_frames_i(rx_frames), .rx_go_i(rx_go), .tx_empty_i(tx_empty),
    .tx_data_i(tx_data), .tx_pop_o(tx_pop), .rx_push_o(rx_push),
    .rx_data_o(rx_data), .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso),
    .ss_no(ss_n), .busy_o(busy)
  );

  always @(posedge clk)
    if (slv_rst) tx_rd <= 0;
    else if (tx_pop) tx_rd <= tx_rd + 1;

  // slave model and observers, all at the falling system clock
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (slv_rst) begin
      sf = 0; sb = nbits - 1; rx_n = 0; low_cnt = 0; edges = 0;
      fall_cyc = -1; first_cyc = -1; ss_bad = 0; bsy_bad = 0; prev = sclk;
      for (int i = 0; i < 8; i++) cap[i] = '0;
    end else begin
      if (ss_n != 4'hF) begin
        low_cnt = low_cnt + 1;
        if (fall_cyc < 0) fall_cyc = cyc;
        if (ss_n != ~sel) ss_bad = ss_bad + 1;
        if (!busy) bsy_bad = bsy_bad + 1;
      end
      if (sclk != prev) begin
        edges = edges + 1;
        if (first_cyc < 0) first_cyc = cyc;
        if ((sclk != ctrl[7]) != ctrl[6]) begin
          cap[sf[2:0]] = {cap[sf[2:0]][14:0], mosi};
          if (sb == 0) begin sf = sf + 1; sb = nbits - 1; end
          else sb = sb - 1;
        end
      end
      prev = sclk;
      if (rx_push) begin
        got[rx_n[2:0]] = rx_data;
        rx_n = rx_n + 1;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] msk(input int n);
    return 16'((32'd1 << n) - 1);
  endfunction

  task automatic setup(input int mode, input int pol, input int pha, input int n,
                       input int d, input int nfr);
    @(negedge clk);
    slv_rst = 1'b1;
    ctrl  = {2'(mode), 1'(pol), 1'(pha), 2'b00, 4'(n - 1)};
    div   = 16'(d);
    nbits = n;
    for (int k = 0; k < 8; k++) begin
      tx_q[k] = 16'hA5C3 ^ 16'(k * 16'h1357) ^ 16'(n * 16'h0101);
      sw[k]   = 16'h3C5A + 16'(k * 16'h2469) + 16'(pol * 7 + pha * 3);
    end
    tx_wr = nfr;
    repeat (2) @(negedge clk);
    slv_rst = 1'b0;
  endtask

  task automatic drain;
    int g;
    g = 0;
    repeat (3) @(negedge clk);
    while (busy && g < 5000) begin @(negedge clk); g = g + 1; end
    repeat (4) @(negedge clk);
  endtask

  task automatic run(input int mode, input int pol, input int pha, input int n,
                     input int d, input int nfr, input string tg);
    int half, bad_tx, bad_rx;
    half = d / 2;
    setup(mode, pol, pha, n, d, nfr);
    if (mode == 2) begin
      rx_frames = 16'(nfr);
      rx_go = 1'b1;
      @(negedge clk);
      rx_go = 1'b0;
    end
    drain();
    bad_tx = 0; bad_rx = 0;
    for (int k = 0; k < nfr; k++) begin
      if (cap[k] != ((mode == 2) ? 16'h0 : (tx_q[k] & msk(n)))) bad_tx++;
      if (mode != 1 && got[k] != (sw[k] & msk(n))) bad_rx++;
    end
    chk({tg, " R1 R2 mosi words wrong"}, bad_tx, 0);
    if (mode != 1) chk({tg, " R1 R2 rx words wrong"}, bad_rx, 0);
    chk({tg, " R3 R4 R5 pops"}, tx_rd, (mode == 2) ? 0 : nfr);
    chk({tg, " R3 R4 R5 pushes"}, rx_n, (mode == 1) ? 0 : nfr);
    chk({tg, " R7 R9 ss low cycles"}, low_cnt, 2 * n * half * nfr);
    chk({tg, " R7 first edge delay"}, first_cyc - fall_cyc, half);
    chk({tg, " R7 edge count"}, edges, 2 * n * nfr);
    chk({tg, " R9 ss lines"}, ss_bad, 0);
    chk({tg, " R10 busy during burst"}, bsy_bad, 0);
    chk({tg, " R10 busy after burst"}, int'(busy), 0);
  endtask

  task automatic stall(input int mode, input int d, input string tg);
    setup(mode, 0, 0, 8, d, 2);
    repeat (100) @(negedge clk);
    chk({tg, " no pop"}, tx_rd, 0);
    chk({tg, " no sclk edge"}, edges, 0);
    chk({tg, " ss stays high"}, low_cnt, 0);
    chk({tg, " busy"}, int'(busy), (mode == 3) ? 0 : 1);
  endtask

  initial begin
    cyc = 0; nbits = 8; tx_wr = 0;
    for (int k = 0; k < 8; k++) begin tx_q[k] = '0; sw[k] = '0; got[k] = '0; end
    repeat (3) @(negedge clk);
    chk("R9 reset ss high", int'(ss_n), 15);
    chk("R2 reset sclk idle", int'(sclk), 0);
    chk("R10 reset busy", int'(busy), 0);
    chk("R3 reset pop", int'(tx_pop), 0);
    chk("R3 reset push", int'(rx_push), 0);
    rst_n = 1'b1;
    // mode 0 sweep over phase, polarity, frame length and divider (odd divider same as even)
    for (int pol = 0; pol < 2; pol++)
      for (int pha = 0; pha < 2; pha++)
        for (int ni = 0; ni < 4; ni++)
          for (int di = 0; di < 2; di++)
            run(0, pol, pha, (ni == 0) ? 1 : (ni == 1) ? 5 : (ni == 2) ? 8 : 16,
                (di == 0) ? 2 : 7, 3, "sweep");
    run(1, 0, 1, 8, 4, 3, "R4 txonly");
    run(1, 1, 0, 12, 2, 2, "R4 txonly");
    run(2, 0, 0, 12, 2, 4, "R5 rxonly");
    run(2, 1, 1, 7, 6, 3, "R5 rxonly");
    stall(3, 4, "R6 reserved mode");
    stall(0, 0, "R8 divider 0");
    stall(0, 1, "R8 divider 1");
    run(0, 0, 0, 8, 3, 1, "R7 div3 half1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end
endmodule